// File: doc/BRIEF.md
# Multi-Block Erase Queue Timer

This block gathers the set of memory blocks that one block-erase request is to clear. It serves a 256 KB byte-wide array split into seven blocks of unequal size. There are three 64 KB main blocks, one 32 KB main block, two 8 KB parameter blocks and one 16 KB boot block. Only bus address bits 17..13 select the block, so only those five bits enter the block.

An upstream command decoder checks the unlock and set-up cycles. It raises `seq_done` on the bus write that completes a full erase sequence. When that write carries the confirm code 30h, the block opens an acceptance window and marks the addressed block in a seven-bit selection mask. While the window is open, any further write of 30h adds its block and restarts the window, with no unlock cycles needed. Any other code written in the window aborts the request.

When the window has run `WIN_CYCLES` clock cycles with no new confirm, it closes. The block then removes locked blocks from the mask, unless the temporary-unprotect input is high. If any block is left, it issues a one-cycle erase launch strobe. If none is left, it pulses an all-locked flag. The window-open output serves as the erase-timer status bit.

Top module: `erase_queue_timer`

## Requirements
- R1: With the default top-boot layout, `wr_blk_addr` (address bits 17..13) decodes to mask bit 0 for 00000h-0FFFFh, bit 1 for 10000h-1FFFFh, bit 2 for 20000h-2FFFFh, bit 3 for 30000h-37FFFh, bit 4 for 38000h-39FFFh, bit 5 for 3A000h-3BFFFh and bit 6 for 3C000h-3FFFFh.
- R2: While the window is closed, a write with `wr_data` = 30h and `seq_done` high opens the window. From the next cycle, `blk_sel` holds only the addressed block's bit, and any earlier mask is dropped.
- R3: While the window is open, a write of 30h ORs the addressed block's bit into `blk_sel` and restarts the window, whatever `seq_done` is. This also holds on the window's last cycle.
- R4: After the last accepted confirm, `win_open` stays high for exactly `WIN_CYCLES` cycles. In the cycle after it falls, exactly one of `erase_go` and `all_locked` is high, for one cycle only.
- R5: When the window closes, every bit set in `blk_lock` (sampled on that closing edge) is cleared from `blk_sel`, unless `unprot_override` is high on that edge. `blk_sel` then holds the filtered mask until the next opening or abort.
- R6: If the filtered mask is empty, `all_locked` pulses and `erase_go` stays low.
- R7: A write with any code other than 30h while the window is open closes the window from the next cycle and clears `blk_sel`. No strobe follows.
- R8: While the window is closed, writes without `seq_done`, and writes with a code other than 30h, change no output.
- R9: During and after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_blk_addr | input | 5 | Address bits 17..13 of the write |
| wr_data | input | 8 | Data byte of the write |
| seq_done | input | 1 | Write completes a checked erase sequence |
| blk_lock | input | 7 | Per-block lock (protection) bits |
| unprot_override | input | 1 | Temporary unprotect: ignore `blk_lock` |
| blk_sel | output | 7 | Collected, later filtered, block mask |
| erase_go | output | 1 | One-cycle erase launch strobe |
| win_open | output | 1 | Acceptance window running (erase-timer status) |
| all_locked | output | 1 | One-cycle flag: every selected block was locked |

## Verification
The bench aims at the window edges. It places a confirm on the window's last open cycle, where a design that let expiry win would launch early with a short mask. It counts the open cycles after a restart, where an off-by-one counter would show a window one cycle long or short. It checks the locking filter with the override both low and high, and a request made only of locked blocks, where a wrong design would strobe an erase with an empty mask. It also aborts with a non-confirm code, and sends confirm-like writes without `seq_done`, which a loose design would take as an opening.

// File: rtl/erq_pkg.sv
package erq_pkg;
  localparam int NUM_BLK   = 7;
  localparam int BLK_IDX_W = 5;
  localparam logic [7:0] CFM_CODE = 8'h30;
  typedef logic [NUM_BLK-1:0] blk_mask_t;
endpackage

// File: rtl/erq_blk_decode.sv
module erq_blk_decode
  import erq_pkg::*;
#(
  parameter bit BOOT_TOP = 1'b1
) (
  input  logic [BLK_IDX_W-1:0] blk_addr,
  output blk_mask_t            blk_hot
);
  // blk_addr[4:0] are address bits 17..13
  generate
    if (BOOT_TOP) begin : g_top
      always_comb begin
        blk_hot = '0;
        unique case (blk_addr[4:3])
          2'b00: blk_hot[0] = 1'b1;
          2'b01: blk_hot[1] = 1'b1;
          2'b10: blk_hot[2] = 1'b1;
          default: begin
            if (!blk_addr[2])      blk_hot[3] = 1'b1;
            else if (blk_addr[1])  blk_hot[6] = 1'b1;
            else if (blk_addr[0])  blk_hot[5] = 1'b1;
            else                   blk_hot[4] = 1'b1;
          end
        endcase
      end
    end else begin : g_bottom
      always_comb begin
        blk_hot = '0;
        unique case (blk_addr[4:3])
          2'b01: blk_hot[4] = 1'b1;
          2'b10: blk_hot[5] = 1'b1;
          2'b11: blk_hot[6] = 1'b1;
          default: begin
            if (blk_addr[2])       blk_hot[3] = 1'b1;
            else if (!blk_addr[1]) blk_hot[0] = 1'b1;
            else if (blk_addr[0])  blk_hot[2] = 1'b1;
            else                   blk_hot[1] = 1'b1;
          end
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/erq_win_timer.sv
module erq_win_timer #(
  parameter int WIN_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic abort,
  output logic open,
  output logic expire
);
  localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          open_d;
  logic          cnt_en;

  assign expire = open && !load && !abort && (cnt_q == '0);

  always_comb begin
    open_d = open;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (abort) begin
      open_d = 1'b0;
    end else if (load) begin
      open_d = 1'b1;
      cnt_d  = CNT_TOP;
      cnt_en = 1'b1;
    end else if (open) begin
      if (cnt_q == '0) begin
        open_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open  <= 1'b0;
      cnt_q <= '0;
    end else begin
      open <= open_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/erq_mask_reg.sv
module erq_mask_reg
  import erq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      add,
  input  logic      abort,
  input  logic      expire,
  input  blk_mask_t blk_hot,
  input  blk_mask_t lock,
  input  logic      override,
  output blk_mask_t mask,
  output logic      go,
  output logic      none_left
);
  blk_mask_t mask_d, kept;
  logic      mask_en, go_d, none_d;

  assign kept = mask & ~(override ? blk_mask_t'('0) : lock);

  always_comb begin
    mask_d  = mask;
    mask_en = 1'b0;
    go_d    = 1'b0;
    none_d  = 1'b0;
    if (start) begin
      mask_d  = blk_hot;
      mask_en = 1'b1;
    end else if (add) begin
      mask_d  = mask | blk_hot;
      mask_en = 1'b1;
    end else if (abort) begin
      mask_d  = '0;
      mask_en = 1'b1;
    end else if (expire) begin
      mask_d  = kept;
      mask_en = 1'b1;
      go_d    = |kept;
      none_d  = ~|kept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '0;
      go        <= 1'b0;
      none_left <= 1'b0;
    end else begin
      if (mask_en) mask <= mask_d;
      go        <= go_d;
      none_left <= none_d;
    end
  end
endmodule

// File: rtl/erase_queue_timer.sv
module erase_queue_timer
  import erq_pkg::*;
#(
  parameter int WIN_CYCLES = 10000,
  parameter bit BOOT_TOP   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [BLK_IDX_W-1:0] wr_blk_addr,
  input  logic [7:0]           wr_data,
  input  logic                 seq_done,
  input  logic [NUM_BLK-1:0]   blk_lock,
  input  logic                 unprot_override,
  output logic [NUM_BLK-1:0]   blk_sel,
  output logic                 erase_go,
  output logic                 win_open,
  output logic                 all_locked
);
  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  blk_mask_t hot;
  logic      is_cfm, start, add, abort, expire;

  assign is_cfm = wr_stb && (wr_data == CFM_CODE);
  assign start  = is_cfm && seq_done && !win_open;
  assign add    = is_cfm && win_open;
  assign abort  = wr_stb && (wr_data != CFM_CODE) && win_open;

  erq_blk_decode #(.BOOT_TOP(BOOT_TOP)) dec_i (
    .blk_addr (wr_blk_addr),
    .blk_hot  (hot)
  );

  erq_win_timer #(.WIN_CYCLES(WIN_CYCLES)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (start || add),
    .abort  (abort),
    .open   (win_open),
    .expire (expire)
  );

  erq_mask_reg msk_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .add       (add),
    .abort     (abort),
    .expire    (expire),
    .blk_hot   (hot),
    .lock      (blk_lock),
    .override  (unprot_override),
    .mask      (blk_sel),
    .go        (erase_go),
    .none_left (all_locked)
  );
endmodule

// File: rtl/erq_checker.sv
module erq_checker
  import erq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_stb,
  input logic [7:0]         wr_data,
  input logic               seq_done,
  input logic [NUM_BLK-1:0] blk_lock,
  input logic               unprot_override,
  input logic [NUM_BLK-1:0] blk_sel,
  input logic               erase_go,
  input logic               win_open,
  input logic               all_locked
);
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_go && all_locked));

  p_go_after_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go || all_locked) |-> ($past(win_open) && !win_open));

  p_go_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go);

  p_go_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (blk_sel != '0));

  p_lock_filtered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go && !$past(unprot_override)) |-> ((blk_sel & $past(blk_lock)) == '0));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && wr_stb && wr_data != CFM_CODE)
      |=> (!win_open && blk_sel == '0 && !erase_go && !all_locked));

  p_ignore_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && (!wr_stb || !seq_done || wr_data != CFM_CODE))
      |=> (!win_open && $stable(blk_sel)));
endmodule

bind erase_queue_timer erq_checker chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_stb          (wr_stb),
  .wr_data         (wr_data),
  .seq_done        (seq_done),
  .blk_lock        (blk_lock),
  .unprot_override (unprot_override),
  .blk_sel         (blk_sel),
  .erase_go        (erase_go),
  .win_open        (win_open),
  .all_locked      (all_locked)
);

// File: tb/erase_queue_timer_tb_top.sv
module erase_queue_timer_tb_top;
  localparam int WIN = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [4:0] wr_blk_addr = '0;
  logic [7:0] wr_data = '0;
  logic       seq_done = 1'b0;
  logic [6:0] blk_lock = '0;
  logic       unprot_override = 1'b0;
  logic [6:0] blk_sel;
  logic       erase_go, win_open, all_locked;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R9";

  always #4 clk = ~clk;

  erase_queue_timer #(.WIN_CYCLES(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_blk_addr(wr_blk_addr),
    .wr_data(wr_data), .seq_done(seq_done), .blk_lock(blk_lock),
    .unprot_override(unprot_override), .blk_sel(blk_sel), .erase_go(erase_go),
    .win_open(win_open), .all_locked(all_locked)
  );

  // behavioural reference
  function automatic int blk_of(input logic [4:0] a5);
    int a = int'(a5) * 8192;
    if (a < 'h10000) return 0;
    if (a < 'h20000) return 1;
    if (a < 'h30000) return 2;
    if (a < 'h38000) return 3;
    if (a < 'h3A000) return 4;
    if (a < 'h3C000) return 5;
    return 6;
  endfunction

  bit   m_open = 0, m_go = 0, m_all = 0;
  int   m_rem = 0;
  logic [6:0] m_mask = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_go = 0; m_all = 0; m_rem = 0; m_mask = '0;
    end else begin
      bit c30;
      logic [6:0] kept;
      m_go = 0; m_all = 0;
      c30 = wr_stb && wr_data == 8'h30;
      if (m_open) begin
        if (wr_stb && !c30) begin
          m_open = 0; m_mask = '0;
        end else if (c30) begin
          m_mask[blk_of(wr_blk_addr)] = 1'b1; m_rem = WIN;
        end else begin
          m_rem = m_rem - 1;
          if (m_rem == 0) begin
            kept = unprot_override ? m_mask : (m_mask & ~blk_lock);
            m_open = 0; m_mask = kept;
            if (kept != 0) m_go = 1; else m_all = 1;
          end
        end
      end else if (c30 && seq_done) begin
        m_open = 1; m_mask = '0; m_mask[blk_of(wr_blk_addr)] = 1'b1; m_rem = WIN;
      end
    end
  end

  task automatic ck(input bit ok, input string req, input string what,
                    input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      ck(blk_sel == m_mask, cur_req, "blk_sel", int'(blk_sel), int'(m_mask));
      ck(win_open == m_open, cur_req, "win_open", int'(win_open), int'(m_open));
      ck(erase_go == m_go, cur_req, "erase_go", int'(erase_go), int'(m_go));
      ck(all_locked == m_all, cur_req, "all_locked", int'(all_locked), int'(m_all));
    end
  end

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic wr(input logic [4:0] a, input logic [7:0] d, input bit sq);
    wr_stb = 1'b1; wr_blk_addr = a; wr_data = d; seq_done = sq;
    @(negedge clk);
    wr_stb = 1'b0; seq_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit done = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // block base addresses (bits 17..13) for the top-boot map
  logic [4:0] base [7] = '{5'h00, 5'h08, 5'h10, 5'h18, 5'h1C, 5'h1D, 5'h1E};

  initial begin
    int n;
    idle(3);
    @(negedge clk);
    ck(blk_sel == 0 && !win_open && !erase_go && !all_locked, "R9", "reset outputs",
       {blk_sel, win_open, erase_go, all_locked}, 0);
    rst_n = 1'b1;
    idle(4);
    ck(blk_sel == 0 && !win_open, "R9", "after release", {blk_sel, win_open}, 0);

    // R1 decode of every block, then R7 abort
    for (int b = 0; b < 7; b++) begin
      cur_req = "R1";
      wr(base[b] + ((b < 3) ? 5'd5 : 5'd0), 8'h30, 1'b1);
      ck(blk_sel == (7'd1 << b), "R1", "decoded block", int'(blk_sel), 1 << b);
      ck(win_open, "R2", "window opened", int'(win_open), 1);
      cur_req = "R7";
      wr(5'h00, 8'hF0, 1'b0);
      ck(!win_open && blk_sel == 0, "R7", "abort clears", {win_open, blk_sel}, 0);
      idle(2);
    end

    // R8: closed-window writes ignored
    cur_req = "R8";
    wr(5'h08, 8'h30, 1'b0);
    wr(5'h08, 8'h80, 1'b1);
    ck(!win_open && blk_sel == 0, "R8", "ignored while closed", {win_open, blk_sel}, 0);
    idle(2);

    // R3/R4: add and restart, count window length
    cur_req = "R3";
    wr(5'h00, 8'h30, 1'b1);
    idle(5);
    wr(5'h10, 8'h30, 1'b0);
    ck(blk_sel == 7'b0000101, "R3", "added block", int'(blk_sel), 'h05);
    cur_req = "R4";
    n = 0;
    while (win_open) begin n++; @(negedge clk); end
    ck(n == WIN, "R4", "window length", n, WIN);
    ck(erase_go && blk_sel == 7'b0000101, "R4", "launch strobe", {erase_go, blk_sel}, 'h85);
    @(negedge clk);
    ck(!erase_go, "R4", "strobe one cycle", int'(erase_go), 0);

    // R5: locked block filtered, then override
    cur_req = "R5";
    blk_lock = 7'b0000100;
    wr(5'h00, 8'h30, 1'b1);
    wr(5'h10, 8'h30, 1'b0);
    idle(WIN);
    ck(erase_go && blk_sel == 7'b0000001, "R5", "locked removed", {erase_go, blk_sel}, 'h81);
    idle(3);
    unprot_override = 1'b1;
    wr(5'h00, 8'h30, 1'b1);
    wr(5'h10, 8'h30, 1'b0);
    idle(WIN);
    ck(erase_go && blk_sel == 7'b0000101, "R5", "override keeps", {erase_go, blk_sel}, 'h85);
    unprot_override = 1'b0;
    idle(3);

    // R6: only locked blocks
    cur_req = "R6";
    blk_lock = 7'b1000000;
    wr(5'h1F, 8'h30, 1'b1);
    idle(WIN);
    ck(all_locked && !erase_go && blk_sel == 0, "R6", "all locked",
       {all_locked, erase_go, blk_sel}, 'h100);
    blk_lock = '0;
    idle(3);

    // R3: confirm on the last open cycle restarts
    cur_req = "R3";
    wr(5'h18, 8'h30, 1'b1);
    idle(WIN - 1);
    ck(win_open, "R3", "last open cycle", int'(win_open), 1);
    wr(5'h1C, 8'h30, 1'b0);
    ck(win_open && blk_sel == 7'b0011000, "R3", "late confirm accepted",
       {win_open, blk_sel}, 'h98);
    idle(WIN);
    ck(erase_go && blk_sel == 7'b0011000, "R4", "late launch", {erase_go, blk_sel}, 'h98);

    // R2: new request drops the held mask
    cur_req = "R2";
    idle(2);
    wr(5'h1D, 8'h30, 1'b1);
    ck(blk_sel == 7'b0100000, "R2", "fresh mask", int'(blk_sel), 'h20);
    idle(WIN + 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule